// File: doc/BRIEF.md
# Framed Synchronous Serial Receiver

This block receives serial words that arrive on a data line. An external bit clock paces the bits, and a frame sync line marks where each word begins. The bit clock, frame sync and data inputs pass through a short synchronizer into the system clock domain. The receiver then samples data and frame sync on every falling edge of the bit clock.

The frame sync can be programmed in two ways. Its width is either a single bit or a whole word. Its position is either on the first data bit or one bit ahead of it. Completed words are right-justified and written into a receive store. When the FIFO is enabled, the store holds eight words. When it is disabled, the store is a single holding register.

A ready flag reports that the stored count has reached a programmable watermark. A maskable interrupt request follows the ready flag. A sticky overrun flag records words that were dropped. A soft init control holds the whole receive path in its reset state for as long as it is set.

Top module: `framed_serial_rx`

## Requirements
- R1: The word length select chooses the number of bits per word: 0 gives 8, 1 gives 12, 2 gives 16 and 3 gives 24. Bits arrive MSB first and are sampled on falling edges of the bit clock. The read data is right-justified, and its unused upper bits read as zero.
- R2: With early sync off, the falling edge at which frame sync is first sampled high carries the word's MSB.
- R3: With early sync on, frame sync is sampled high one bit before the MSB. The data bit sampled alongside that frame sync is ignored.
- R4: In bit-length sync mode, a frame sync sampled high starts a word. In word-length sync mode, only a low-to-high change of the sampled frame sync starts a word, so a frame sync held high across the word does not restart reception.
- R5: A start detected while a word is partly received restarts reception. The partial word is never stored.
- R6: With the FIFO disabled, the store holds one word. Ready is set when a word lands and cleared when it is read. A word that completes while one is held is dropped and sets overrun.
- R7: With the FIFO enabled, up to eight words are returned in arrival order. Ready is high exactly while occupancy is at or above the watermark. A watermark of 0 acts as 1 and values above 8 act as 8. A read that brings occupancy below the watermark clears ready.
- R8: A word that completes while eight are held is dropped. The eight held words are kept intact, and a sticky overrun flag is set.
- R9: The interrupt request equals ready gated by the interrupt enable.
- R10: While init is high, the store is empty, overrun is clear and words on the line are not captured. Reception resumes once init returns to 0.
- R11: After reset, ready, interrupt and overrun are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | External bit clock |
| ser_fs_i | input | 1 | Frame sync |
| ser_dat_i | input | 1 | Serial data |
| cfg_wl_i | input | 2 | Word length select (0:8, 1:12, 2:16, 3:24) |
| cfg_fs_word_i | input | 1 | 1 = word-length frame sync, 0 = bit-length |
| cfg_fs_early_i | input | 1 | 1 = frame sync one bit ahead of the MSB |
| cfg_fifo_en_i | input | 1 | 1 = eight-entry FIFO, 0 = single register |
| cfg_wmark_i | input | 4 | Watermark for ready (1 to 8) |
| cfg_irq_en_i | input | 1 | Interrupt enable |
| cfg_init_i | input | 1 | Soft init, holds the receive path in reset |
| rd_en_i | input | 1 | Pops the head word (ignored when empty) |
| rd_data_o | output | 24 | Head word, right-justified |
| rx_ready_o | output | 1 | Occupancy at or above the watermark |
| rx_irq_o | output | 1 | Interrupt request |
| rx_ovr_o | output | 1 | Sticky overrun |

## Verification
The hardest state to reach is a full eight-entry store that then receives a ninth completed word. The bench reaches it by turning off its draining monitor, raising the watermark to 8, and sending eight framed words and then a ninth. It then confirms that overrun rises and that all eight held words come back in order.

A second hard case is a restart in the middle of a word. The bench reaches it by sending a frame sync followed by only a few bits, then a new full frame. The scoreboard must then see only the second word.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    typedef enum logic [1:0] {
        WL_8  = 2'd0,
        WL_12 = 2'd1,
        WL_16 = 2'd2,
        WL_24 = 2'd3
    } wl_sel_e;

    typedef struct packed {
        logic       fs_word;
        logic       fs_early;
        logic [1:0] wl;
    } frame_cfg_t;

    function automatic logic [4:0] wl_bits(input logic [1:0] sel);
        logic [4:0] n;
        case (wl_sel_e'(sel))
            WL_8:    n = 5'd8;
            WL_12:   n = 5'd12;
            WL_16:   n = 5'd16;
            default: n = 5'd24;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/fsr_sync_edge.sv
module fsr_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic fs_i,
    input  logic dat_i,
    output logic bit_fall_o,
    output logic fs_o,
    output logic dat_o
);

    typedef struct packed {
        logic [STAGES-1:0] sclk;
        logic [STAGES-1:0] fs;
        logic [STAGES-1:0] dat;
        logic              sclk_prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d         = s_q;
        s_d.sclk[0] = sclk_i;
        s_d.fs[0]   = fs_i;
        s_d.dat[0]  = dat_i;
        for (int i = 1; i < STAGES; i++) begin
            s_d.sclk[i] = s_q.sclk[i-1];
            s_d.fs[i]   = s_q.fs[i-1];
            s_d.dat[i]  = s_q.dat[i-1];
        end
        s_d.sclk_prev = s_q.sclk[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bit_fall_o = s_q.sclk_prev & ~s_q.sclk[STAGES-1];
    assign fs_o       = s_q.fs[STAGES-1];
    assign dat_o      = s_q.dat[STAGES-1];

endmodule

// File: rtl/fsr_shift.sv
module fsr_shift
    import fsr_pkg::*;
#(
    parameter  int W    = 24,
    localparam int CNTW = $clog2(W + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         init_i,
    input  logic         bit_fall_i,
    input  logic         fs_i,
    input  logic         dat_i,
    input  frame_cfg_t   cfg_i,
    output logic         word_valid_o,
    output logic [W-1:0] word_o
);

    typedef struct packed {
        logic            active;
        logic [CNTW-1:0] cnt;
        logic [W-1:0]    sh;
        logic            fs_prev;
        logic            done;
        logic [W-1:0]    word;
    } shift_t;

    shift_t          s_d, s_q;
    logic [CNTW-1:0] wl_n;
    logic [CNTW-1:0] cnt_inc;
    logic [W-1:0]    sh_next;
    logic            start;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        wl_n     = CNTW'(wl_bits(cfg_i.wl));
        cnt_inc  = s_q.cnt + CNTW'(1);
        sh_next  = {s_q.sh[W-2:0], dat_i};
        start    = cfg_i.fs_word ? (fs_i & ~s_q.fs_prev) : fs_i;
        if (bit_fall_i) begin
            s_d.fs_prev = fs_i;
            if (start) begin
                s_d.active = 1'b1;
                if (cfg_i.fs_early) begin
                    s_d.cnt = '0;
                    s_d.sh  = '0;
                end else begin
                    s_d.cnt = CNTW'(1);
                    s_d.sh  = W'(dat_i);
                end
            end else if (s_q.active) begin
                s_d.sh  = sh_next;
                s_d.cnt = cnt_inc;
                if (cnt_inc == wl_n) begin
                    s_d.done   = 1'b1;
                    s_d.word   = sh_next;
                    s_d.active = 1'b0;
                end
            end
        end
        if (init_i) s_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign word_valid_o = s_q.done;
    assign word_o       = s_q.word;

    AST_CNT_BELOW_WL: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.active |-> (s_q.cnt < wl_n));                         // R1
    AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |-> $past(bit_fall_i));                          // R1
    AST_INIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> (!s_q.active && !s_q.done));                   // R10

endmodule

// File: rtl/fsr_rx_fifo.sv
module fsr_rx_fifo #(
    parameter  int DEPTH = 8,
    parameter  int W     = 24,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init_i,
    input  logic          fifo_en_i,
    input  logic [CW-1:0] wmark_i,
    input  logic          irq_en_i,
    input  logic          push_i,
    input  logic [W-1:0]  push_data_i,
    input  logic          pop_i,
    output logic [W-1:0]  rd_data_o,
    output logic          ready_o,
    output logic          irq_o,
    output logic          ovr_o
);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wr_ptr;
        logic [AW-1:0]           rd_ptr;
        logic [CW-1:0]           cnt;
        logic                    ovr;
    } fifo_t;

    fifo_t         s_d, s_q;
    logic [CW-1:0] cap;
    logic [CW-1:0] wm_eff;
    logic          do_pop;
    logic          do_push;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        cap = fifo_en_i ? CW'(DEPTH) : CW'(1);
        if (!fifo_en_i || wmark_i == '0) wm_eff = CW'(1);
        else if (wmark_i > CW'(DEPTH))   wm_eff = CW'(DEPTH);
        else                             wm_eff = wmark_i;
    end

    always_comb begin
        s_d     = s_q;
        do_pop  = pop_i && (s_q.cnt != '0);
        do_push = push_i && ((s_q.cnt != cap) || do_pop);
        if (do_pop) s_d.rd_ptr = ptr_next(s_q.rd_ptr);
        if (do_push) begin
            s_d.mem[s_q.wr_ptr] = push_data_i;
            s_d.wr_ptr          = ptr_next(s_q.wr_ptr);
        end
        if (push_i && !do_push) s_d.ovr = 1'b1;
        case ({do_push, do_pop})
            2'b10:   s_d.cnt = s_q.cnt + CW'(1);
            2'b01:   s_d.cnt = s_q.cnt - CW'(1);
            default: s_d.cnt = s_q.cnt;
        endcase
        if (init_i) s_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_data_o = s_q.mem[s_q.rd_ptr];
    assign ready_o   = (s_q.cnt >= wm_eff);
    assign irq_o     = ready_o & irq_en_i;
    assign ovr_o     = s_q.ovr;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CW'(DEPTH));                                   // R8
    AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && !init_i && s_q.cnt == cap)
            |=> (s_q.cnt == $past(s_q.cnt)) && s_q.ovr);          // R8
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ovr && !init_i) |=> s_q.ovr);                        // R8
    AST_INIT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> (s_q.cnt == '0) && !s_q.ovr);                  // R10
    AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && s_q.cnt == '0) |=> (s_q.cnt == '0)); // R7

endmodule

// File: rtl/framed_serial_rx.sv
module framed_serial_rx
    import fsr_pkg::*;
#(
    parameter  int DEPTH  = 8,
    parameter  int WORD_W = 24,
    parameter  int SYNC   = 2,
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk_i,
    input  logic              ser_fs_i,
    input  logic              ser_dat_i,
    input  logic [1:0]        cfg_wl_i,
    input  logic              cfg_fs_word_i,
    input  logic              cfg_fs_early_i,
    input  logic              cfg_fifo_en_i,
    input  logic [CW-1:0]     cfg_wmark_i,
    input  logic              cfg_irq_en_i,
    input  logic              cfg_init_i,
    input  logic              rd_en_i,
    output logic [WORD_W-1:0] rd_data_o,
    output logic              rx_ready_o,
    output logic              rx_irq_o,
    output logic              rx_ovr_o
);

    logic              bit_fall;
    logic              fs_s;
    logic              dat_s;
    logic              word_valid;
    logic [WORD_W-1:0] word;
    frame_cfg_t        fcfg;

    assign fcfg = '{fs_word: cfg_fs_word_i, fs_early: cfg_fs_early_i, wl: cfg_wl_i};

    fsr_sync_edge #(.STAGES(SYNC)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_i     (ser_clk_i),
        .fs_i       (ser_fs_i),
        .dat_i      (ser_dat_i),
        .bit_fall_o (bit_fall),
        .fs_o       (fs_s),
        .dat_o      (dat_s)
    );

    fsr_shift #(.W(WORD_W)) u_shift (
        .clk          (clk),
        .rst_n        (rst_n),
        .init_i       (cfg_init_i),
        .bit_fall_i   (bit_fall),
        .fs_i         (fs_s),
        .dat_i        (dat_s),
        .cfg_i        (fcfg),
        .word_valid_o (word_valid),
        .word_o       (word)
    );

    fsr_rx_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .init_i      (cfg_init_i),
        .fifo_en_i   (cfg_fifo_en_i),
        .wmark_i     (cfg_wmark_i),
        .irq_en_i    (cfg_irq_en_i),
        .push_i      (word_valid),
        .push_data_i (word),
        .pop_i       (rd_en_i),
        .rd_data_o   (rd_data_o),
        .ready_o     (rx_ready_o),
        .irq_o       (rx_irq_o),
        .ovr_o       (rx_ovr_o)
    );

    AST_IRQ_FOLLOWS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq_o |-> (rx_ready_o && cfg_irq_en_i));               // R9

endmodule

// File: tb/tb_framed_serial_rx.sv
`timescale 1ns/1ps
module tb_framed_serial_rx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0, fs = 1'b0, dat = 1'b0;
    logic [1:0]  wl = 2'd0;
    logic        fs_word = 1'b0, fs_early = 1'b0, fifo_en = 1'b0;
    logic [3:0]  wmark = 4'd1;
    logic        irq_en = 1'b1, init = 1'b0;
    logic        mon_rd = 1'b0, man_rd = 1'b0;
    logic        rd_en;
    logic [23:0] rd_data;
    logic        ready, irq, ovr;

    int          checks = 0, errors = 0;
    logic [23:0] exp_q[$];
    bit          drain_on = 1'b0;
    string       tag = "R11";

    always #2.5 clk = ~clk;
    assign rd_en = mon_rd | man_rd;

    framed_serial_rx dut (
        .clk(clk), .rst_n(rst_n), .ser_clk_i(sclk), .ser_fs_i(fs), .ser_dat_i(dat),
        .cfg_wl_i(wl), .cfg_fs_word_i(fs_word), .cfg_fs_early_i(fs_early),
        .cfg_fifo_en_i(fifo_en), .cfg_wmark_i(wmark), .cfg_irq_en_i(irq_en),
        .cfg_init_i(init), .rd_en_i(rd_en), .rd_data_o(rd_data),
        .rx_ready_o(ready), .rx_irq_o(irq), .rx_ovr_o(ovr)
    );

    task automatic chk(input string t, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
        end
    endtask

    task automatic compare_head();
        if (exp_q.size() == 0) chk(tag, "unexpected word", rd_data, 32'hDEAD);
        else chk(tag, "word", rd_data, exp_q.pop_front());
    endtask

    // monitor: drains and scores words while enabled
    always @(negedge clk) begin
        if (mon_rd) mon_rd = 1'b0;
        else if (drain_on && ready) begin
            compare_head();
            mon_rd = 1'b1;
        end
    end

    task automatic pop_check();
        @(negedge clk);
        compare_head();
        man_rd = 1'b1;
        @(negedge clk);
        man_rd = 1'b0;
    endtask

    task automatic drive_bit(input logic f, input logic d);
        @(negedge clk); sclk = 1'b1; fs = f; dat = d;
        @(negedge clk);
        @(negedge clk); sclk = 1'b0;
        @(negedge clk);
    endtask

    // driver: pushes the expected word, then sends the frame
    task automatic send_word(input logic [23:0] data, input bit keep);
        int nb;
        nb = (wl == 2'd0) ? 8 : (wl == 2'd1) ? 12 : (wl == 2'd2) ? 16 : 24;
        if (keep) exp_q.push_back(data & ((24'd1 << nb) - 24'd1));
        if (fs_early) drive_bit(1'b1, 1'b1);
        for (int i = 0; i < nb; i++) begin
            logic f;
            f = fs_early ? (fs_word && i < nb - 1) : (i == 0 || fs_word);
            drive_bit(f, data[nb-1-i]);
        end
        drive_bit(1'b0, 1'b0);
        drive_bit(1'b0, 1'b0);
    endtask

    task automatic settle();
        repeat (12) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        chk("R11", "ready", ready, 0);
        chk("R11", "irq", irq, 0);
        chk("R11", "ovr", ovr, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        drain_on = 1'b1;
        tag = "R2"; wl = 2'd0; send_word(24'hA5, 1); settle();
        chk("R2", "queue drained", exp_q.size(), 0);
        tag = "R3"; fs_early = 1'b1; wl = 2'd1; send_word(24'hABC, 1); settle();
        chk("R3", "queue drained", exp_q.size(), 0);
        tag = "R4"; fs_early = 1'b0; fs_word = 1'b1; wl = 2'd2; send_word(24'h1234, 1); settle();
        chk("R4", "aligned word sync", exp_q.size(), 0);
        tag = "R1"; fs_early = 1'b1; wl = 2'd3; send_word(24'hC0FFEE, 1); settle();
        chk("R1", "24-bit early word sync", exp_q.size(), 0);

        // R5: partial word, then a new frame
        tag = "R5"; fs_early = 1'b0; fs_word = 1'b0; wl = 2'd0;
        drive_bit(1'b1, 1'b1); drive_bit(1'b0, 1'b1); drive_bit(1'b0, 1'b1);
        send_word(24'h3C, 1); settle();
        chk("R5", "only restarted word", exp_q.size(), 0);
        drain_on = 1'b0;

        // R9
        tag = "R9"; irq_en = 1'b0; send_word(24'h5A, 1); settle();
        chk("R9", "ready", ready, 1);
        chk("R9", "irq masked", irq, 0);
        irq_en = 1'b1; @(negedge clk);
        chk("R9", "irq enabled", irq, 1);
        pop_check(); @(negedge clk);
        chk("R9", "irq after read", irq, 0);

        // R6: single register, second word dropped
        tag = "R6"; send_word(24'h11, 1); send_word(24'h22, 0); settle();
        chk("R6", "ready", ready, 1);
        chk("R6", "ovr", ovr, 1);
        pop_check(); @(negedge clk);
        chk("R6", "ready after read", ready, 0);
        init = 1'b1; repeat (3) @(negedge clk); init = 1'b0; @(negedge clk);
        chk("R10", "ovr cleared by init", ovr, 0);

        // R7: watermark
        tag = "R7"; fifo_en = 1'b1; wmark = 4'd3;
        send_word(24'h01, 1); send_word(24'h02, 1); settle();
        chk("R7", "below watermark", ready, 0);
        send_word(24'h03, 1); settle();
        chk("R7", "at watermark", ready, 1);
        chk("R9", "irq at watermark", irq, 1);
        pop_check(); @(negedge clk);
        chk("R7", "below after read", ready, 0);
        pop_check(); pop_check();
        wmark = 4'd0; send_word(24'h77, 1); settle();
        chk("R7", "watermark 0 acts as 1", ready, 1);
        pop_check(); @(negedge clk);
        chk("R7", "empty", ready, 0);

        // R8: ninth word
        tag = "R8"; wmark = 4'd8;
        for (int k = 0; k < 8; k++) begin
            send_word(24'h80 + 24'(k), 1);
            if (k == 6) begin settle(); chk("R8", "seven held", ready, 0); end
        end
        settle();
        chk("R8", "eight held", ready, 1);
        chk("R8", "no ovr yet", ovr, 0);
        send_word(24'hFF, 0); settle();
        chk("R8", "ovr on ninth", ovr, 1);
        for (int k = 0; k < 8; k++) pop_check();
        @(negedge clk);
        chk("R8", "empty after drain", ready, 0);
        chk("R8", "ovr sticky", ovr, 1);

        // R10: init holds reception
        tag = "R10"; wmark = 4'd1;
        send_word(24'h44, 0); settle();
        init = 1'b1; @(negedge clk);
        exp_q.delete();
        send_word(24'h55, 0); settle();
        chk("R10", "ready during init", ready, 0);
        chk("R10", "ovr during init", ovr, 0);
        init = 1'b0;
        drive_bit(1'b1, 1'b0); drive_bit(1'b0, 1'b1);
        init = 1'b1; @(negedge clk); init = 1'b0;
        settle();
        chk("R10", "partial dropped by init", ready, 0);
        send_word(24'h66, 1); settle();
        chk("R10", "resumes", ready, 1);
        pop_check();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule